// File: doc/BRIEF.md
# Symmetric Dual-Slope PWM Timer

This block is a counter that sweeps from zero up to a ceiling value and back down to zero, over and over. Two compare channels watch the count and each drives a pulse-width modulated pin. The pins switch at the same count on the rising and the falling slope, so every pulse is centred in its period. The ceiling (TOP) can be one of three fixed values. It can also come from a period register or from the channel A compare value.

A single write port loads the two compare buffers and the period register, and it clears the sticky flags. Compare values are double-buffered. A write lands in a buffer, and the working copy takes the buffer value when the counter turns around at TOP, so a new duty cycle never starts in the middle of a period. The counter moves only on cycles where `tick` is high.

The count sequencer is a two-state machine:
- **CNT_UP** goes to **CNT_DOWN** on the enabled tick at which the count is at or above TOP. This is the *turnaround*.
- **CNT_DOWN** goes to **CNT_UP** on the enabled tick at which the count is zero. This is the *rebound*.

On any other enabled tick, the state stays and the count moves one step in the current direction.

Top module: `sympwm_timer`

## Requirements
- R1: After reset the count is 0, the direction is up, and both pins and all four flags are 0. On each enabled tick the count changes by exactly one.
- R2: `wave_sel` sets TOP as follows:
  - 1 gives 0x00FF.
  - 2 gives 0x01FF.
  - 3 gives 0x03FF.
  - 10 gives the period register.
  - 11 gives the working channel A compare value.
- R3: When counting up, the count stays at TOP for one tick and then steps down; the values seen are TOP-1, TOP, TOP-1. Zero is likewise held for one tick before the count climbs again.
- R4: A pin acts only on an enabled tick at which the count equals that channel's working compare value:
  - Pin mode 2: the pin goes low if the direction is up, and high if it is down.
  - Pin mode 3: the pin goes high if the direction is up, and low if it is down.
- R5: The overflow flag sets on the enabled tick at which the count steps down from 1 to 0.
- R6: Writing with `wr_sel` 0 or 1 loads only the A or B compare buffer. Each working compare value takes its buffer's value only on the turnaround tick.
- R7: With `tick` low, nothing changes: count, direction, pins and working values all hold. With `wave_sel` outside {1,2,3,10,11}, ticks are ignored.
- R8: Each channel's compare flag sets on every enabled tick at which the count equals that channel's working compare value.
- R9: On the turnaround tick, a flag sets depending on the TOP source:
  - With `wave_sel` 10, the period flag sets.
  - With `wave_sel` 11, the channel A compare flag sets.
- R10: Flags are sticky. A write with `wr_sel` 3 clears each flag whose data bit is 1, using this bit map:
  - bit 0: overflow
  - bit 1: compare A
  - bit 2: compare B
  - bit 3: period

  If a flag is set and cleared in the same cycle, the set wins.
- R11: Pin mode 0 or 1 drives the pin to 0, and that channel's internal level is left unchanged.
- R12: A TOP source below 3 is treated as 3. `wr_sel` 2 writes the period register directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer step enable |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 cmp A buffer, 1 cmp B buffer, 2 period, 3 flag clear |
| wr_data | input | W | Write data |
| wave_sel | input | 4 | TOP source select |
| mode_a | input | 2 | Channel A pin mode |
| mode_b | input | 2 | Channel B pin mode |
| pwm_a | output | 1 | Channel A pin |
| pwm_b | output | 1 | Channel B pin |
| flag_ovf | output | 1 | Overflow (bottom) flag |
| flag_cmp_a | output | 1 | Channel A compare flag |
| flag_cmp_b | output | 1 | Channel B compare flag |
| flag_period | output | 1 | Period-register TOP flag |
| count | output | W | Current count |

## Verification
The bench builds the block with the default 16-bit width. At that width the 8-bit fixed TOP gives a full 510-tick period, which is short enough to walk through directly. Ceilings of 3 to about 40, taken from the period register or the channel A compare value, fit hundreds of turnarounds into a short run. That is where buffer loads, compare matches at TOP and at zero, and the clamp to 3 all occur. Random tick gaps, writes and mode changes are compared every cycle against a reference model that the bench builds from the requirements.

// File: rtl/sympwm_pkg.sv
package sympwm_pkg;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        PIN_OFF    = 2'd0,
        PIN_RSVD   = 2'd1,
        PIN_NONINV = 2'd2,
        PIN_INV    = 2'd3
    } pin_mode_e;

    localparam logic [3:0] WAVE_FIX8   = 4'd1;
    localparam logic [3:0] WAVE_FIX9   = 4'd2;
    localparam logic [3:0] WAVE_FIX10  = 4'd3;
    localparam logic [3:0] WAVE_PERIOD = 4'd10;
    localparam logic [3:0] WAVE_CMPA   = 4'd11;

    localparam int unsigned MIN_TOP = 3;

    localparam logic [1:0] SEL_BUF_A = 2'd0;
    localparam logic [1:0] SEL_BUF_B = 2'd1;
    localparam logic [1:0] SEL_PER   = 2'd2;
    localparam logic [1:0] SEL_CLR   = 2'd3;

endpackage

// File: rtl/sympwm_counter.sv
module sympwm_counter
    import sympwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output dir_e         dir,
    output logic         turn,
    output logic         bottom
);

    localparam logic [W-1:0] ONE = W'(1);

    dir_e         st_q, st_d;
    logic [W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CNT_UP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        turn   = 1'b0;
        bottom = 1'b0;
        if (step) begin
            unique case (st_q)
                CNT_UP: begin
                    if (cnt_q >= top) begin
                        st_d  = CNT_DOWN;
                        cnt_d = cnt_q - ONE;
                        turn  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                CNT_DOWN: begin
                    if (cnt_q == '0) begin
                        st_d  = CNT_UP;
                        cnt_d = ONE;
                    end else begin
                        cnt_d  = cnt_q - ONE;
                        bottom = (cnt_q == ONE);
                    end
                end
            endcase
        end
    end

    assign cnt = cnt_q;
    assign dir = st_q;

    // R1: every enabled tick moves the count by one in either direction
    p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((cnt_q - $past(cnt_q)) == ONE) || (($past(cnt_q) - cnt_q) == ONE));

    // R7: without a tick the count and direction hold
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(cnt_q) && $stable(st_q)));

endmodule

// File: rtl/sympwm_channel.sv
module sympwm_channel
    import sympwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         wr_buf,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    input  dir_e         dir,
    input  logic [W-1:0] cnt,
    input  logic [1:0]   mode,
    output logic         pin,
    output logic         match,
    output logic [W-1:0] active
);

    logic [W-1:0] buf_q, act_q;
    logic         lvl_q;
    pin_mode_e    pm;

    assign pm    = pin_mode_e'(mode);
    assign match = step && (cnt == act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            if (wr_buf) buf_q <= wr_data;
            if (load)   act_q <= buf_q;
            if (match) begin
                unique case (pm)
                    PIN_NONINV: lvl_q <= (dir == CNT_DOWN);
                    PIN_INV:    lvl_q <= (dir == CNT_UP);
                    default:    lvl_q <= lvl_q;
                endcase
            end
        end
    end

    always_comb begin
        unique case (pm)
            PIN_NONINV, PIN_INV: pin = lvl_q;
            default:             pin = 1'b0;
        endcase
    end

    assign active = act_q;

    // R6: the working compare value changes only on a turnaround load
    p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_q));

    // R4: with an unchanged mode the pin only moves after a compare match
    p_pin_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == $past(mode)) && (pin != $past(pin))) |-> $past(match));

endmodule

// File: rtl/sympwm_timer.sv
module sympwm_timer
    import sympwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [3:0]   wave_sel,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    output logic         pwm_a,
    output logic         pwm_b,
    output logic         flag_ovf,
    output logic         flag_cmp_a,
    output logic         flag_cmp_b,
    output logic         flag_period,
    output logic [W-1:0] count
);

    localparam int NCH = 2;
    localparam int NFLG = 4;
    localparam logic [W-1:0] TOP8  = W'(10'h0FF);
    localparam logic [W-1:0] TOP9  = W'(10'h1FF);
    localparam logic [W-1:0] TOP10 = W'(10'h3FF);
    localparam logic [W-1:0] TOPMIN = W'(MIN_TOP);

    logic [W-1:0] per_q;
    logic [W-1:0] top_raw, top_eff;
    logic         wave_ok, step, turn, bottom;
    logic [W-1:0] cnt;
    dir_e         dir;

    logic [1:0]   ch_mode  [NCH];
    logic         ch_pin   [NCH];
    logic         ch_match [NCH];
    logic [W-1:0] ch_act   [NCH];

    logic [NFLG-1:0] flg_q, flg_set, flg_clr;

    assign ch_mode[0] = mode_a;
    assign ch_mode[1] = mode_b;

    always_comb begin
        wave_ok = 1'b1;
        unique case (wave_sel)
            WAVE_FIX8:   top_raw = TOP8;
            WAVE_FIX9:   top_raw = TOP9;
            WAVE_FIX10:  top_raw = TOP10;
            WAVE_PERIOD: top_raw = per_q;
            WAVE_CMPA:   top_raw = ch_act[0];
            default: begin
                top_raw = TOP8;
                wave_ok = 1'b0;
            end
        endcase
        top_eff = (top_raw < TOPMIN) ? TOPMIN : top_raw;
    end

    assign step = tick && wave_ok;

    sympwm_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .top    (top_eff),
        .cnt    (cnt),
        .dir    (dir),
        .turn   (turn),
        .bottom (bottom)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sympwm_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step),
            .wr_buf  (wr_en && (wr_sel == 2'(c))),
            .wr_data (wr_data),
            .load    (turn),
            .dir     (dir),
            .cnt     (cnt),
            .mode    (ch_mode[c]),
            .pin     (ch_pin[c]),
            .match   (ch_match[c]),
            .active  (ch_act[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_q <= '0;
        else if (wr_en && (wr_sel == SEL_PER)) per_q <= wr_data;
    end

    always_comb begin
        flg_set[0] = bottom;
        flg_set[1] = ch_match[0] || (turn && (wave_sel == WAVE_CMPA));
        flg_set[2] = ch_match[1];
        flg_set[3] = turn && (wave_sel == WAVE_PERIOD);
        flg_clr    = (wr_en && (wr_sel == SEL_CLR)) ? wr_data[NFLG-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= (flg_q & ~flg_clr) | flg_set;
    end

    assign pwm_a       = ch_pin[0];
    assign pwm_b       = ch_pin[1];
    assign flag_ovf    = flg_q[0];
    assign flag_cmp_a  = flg_q[1];
    assign flag_cmp_b  = flg_q[2];
    assign flag_period = flg_q[3];
    assign count       = cnt;

    // R5: overflow flag rises only as the count lands on zero
    p_ovf_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ovf) |-> (count == '0));

    // R9: period flag rises only with the period register as TOP source
    p_period_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_period) |-> ($past(wave_sel) == WAVE_PERIOD));

    // R12: the count never climbs past a clamped TOP from the period register
    p_top_floor_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((wave_sel == WAVE_PERIOD) && (per_q < TOPMIN) && (count <= TOPMIN)) |=>
        ((count <= TOPMIN) || (wave_sel != WAVE_PERIOD) || $changed(per_q)));

endmodule

// File: tb/sim_sympwm_timer.sv
module sim_sympwm_timer;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [3:0]   wave_sel = 4'd0;
    logic [1:0]   mode_a = 2'd0;
    logic [1:0]   mode_b = 2'd0;
    logic         pwm_a, pwm_b, flag_ovf, flag_cmp_a, flag_cmp_b, flag_period;
    logic [W-1:0] count;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sympwm_timer #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .wave_sel(wave_sel), .mode_a(mode_a), .mode_b(mode_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .flag_ovf(flag_ovf), .flag_cmp_a(flag_cmp_a),
        .flag_cmp_b(flag_cmp_b), .flag_period(flag_period), .count(count)
    );

    // Reference model built from the requirements
    logic [W-1:0] m_cnt, m_act_a, m_act_b, m_buf_a, m_buf_b, m_per;
    logic         m_dir, m_lvl_a, m_lvl_b;
    logic [3:0]   m_flg;

    function automatic logic [W-1:0] top_of(input logic [3:0] ws, input logic [W-1:0] per,
                                            input logic [W-1:0] acta);
        logic [W-1:0] t;
        case (ws)
            4'd1:    t = 16'h00FF;
            4'd2:    t = 16'h01FF;
            4'd3:    t = 16'h03FF;
            4'd10:   t = per;
            4'd11:   t = acta;
            default: t = 16'h00FF;
        endcase
        return (t < 3) ? 16'd3 : t;
    endfunction

    function automatic bit wave_valid(input logic [3:0] ws);
        return (ws == 1) || (ws == 2) || (ws == 3) || (ws == 10) || (ws == 11);
    endfunction

    function automatic logic pin_of(input logic [1:0] md, input logic lvl);
        return md[1] ? lvl : 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= '0; m_dir <= 1'b0; m_act_a <= '0; m_act_b <= '0;
            m_buf_a <= '0; m_buf_b <= '0; m_per <= '0;
            m_lvl_a <= 1'b0; m_lvl_b <= 1'b0; m_flg <= '0;
        end else begin
            logic [W-1:0] tp;
            logic t, trn, bot, ma, mb;
            logic [3:0] set, clr;
            tp  = top_of(wave_sel, m_per, m_act_a);
            t   = tick && wave_valid(wave_sel);
            trn = t && !m_dir && (m_cnt >= tp);
            bot = t && m_dir && (m_cnt == 1);
            ma  = t && (m_cnt == m_act_a);
            mb  = t && (m_cnt == m_act_b);
            if (ma && mode_a[1]) m_lvl_a <= (mode_a == 2'd2) ? m_dir : !m_dir;
            if (mb && mode_b[1]) m_lvl_b <= (mode_b == 2'd2) ? m_dir : !m_dir;
            set = {trn && (wave_sel == 4'd10), mb, ma || (trn && (wave_sel == 4'd11)), bot};
            clr = (wr_en && wr_sel == 2'd3) ? wr_data[3:0] : 4'd0;
            m_flg <= (m_flg & ~clr) | set;
            if (t) begin
                if (!m_dir) begin
                    if (m_cnt >= tp) begin m_dir <= 1'b1; m_cnt <= m_cnt - 1; end
                    else m_cnt <= m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_dir <= 1'b0; m_cnt <= 16'd1; end
                    else m_cnt <= m_cnt - 1;
                end
            end
            if (trn) begin m_act_a <= m_buf_a; m_act_b <= m_buf_b; end
            if (wr_en && wr_sel == 2'd0) m_buf_a <= wr_data;
            if (wr_en && wr_sel == 2'd1) m_buf_b <= wr_data;
            if (wr_en && wr_sel == 2'd2) m_per <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (rst_n) begin
            chk(count == m_cnt, "R1 R2 R3 R12 count", int'(count), int'(m_cnt));
            chk(pwm_a == pin_of(mode_a, m_lvl_a), "R4 R6 R11 pwm_a", pwm_a, pin_of(mode_a, m_lvl_a));
            chk(pwm_b == pin_of(mode_b, m_lvl_b), "R4 R6 R11 pwm_b", pwm_b, pin_of(mode_b, m_lvl_b));
            chk(flag_ovf == m_flg[0], "R5 ovf flag", flag_ovf, m_flg[0]);
            chk({flag_cmp_b, flag_cmp_a} == m_flg[2:1], "R8 R9 cmp flags",
                {flag_cmp_b, flag_cmp_a}, m_flg[2:1]);
            chk(flag_period == m_flg[3], "R9 R10 period flag", flag_period, m_flg[3]);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rand_phase(input int n, input logic [3:0] ws, input int span, input bit hop);
        for (int i = 0; i < n; i++) begin
            if (hop && (i % 500 == 0)) begin
                case ($urandom % 7)
                    0: wave_sel = 4'd1;  1: wave_sel = 4'd2;  2: wave_sel = 4'd3;
                    3: wave_sel = 4'd10; 4: wave_sel = 4'd11; 5: wave_sel = 4'd0;
                    default: wave_sel = 4'd7;
                endcase
            end else if (!hop) wave_sel = ws;
            tick = (($urandom % 8) != 0);
            wr_en = (($urandom % 8) == 0);
            wr_sel = 2'($urandom % 4);
            wr_data = (wr_sel == 2'd3) ? 16'($urandom % 16) : 16'($urandom % span);
            if (($urandom % 64) == 0) mode_a = 2'($urandom % 4);
            if (($urandom % 64) == 0) mode_b = 2'($urandom % 4);
            cyc();
        end
        wr_en = 1'b0;
    endtask

    initial begin
        int seed, n, mx;
        logic [W-1:0] held;
        seed = $urandom(32'h5A17);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(count == 0, "R1 reset count", int'(count), 0);
        chk({pwm_a, pwm_b} == 2'b00, "R1 reset pins", {pwm_a, pwm_b}, 0);
        chk({flag_ovf, flag_cmp_a, flag_cmp_b, flag_period} == 4'b0, "R1 reset flags",
            {flag_ovf, flag_cmp_a, flag_cmp_b, flag_period}, 0);
        rst_n = 1'b1;
        // R2 R3: 8-bit fixed TOP reached after 255 ticks, then steps down
        wave_sel = 4'd1; tick = 1'b1;
        n = 0;
        for (int i = 1; i <= 300; i++) begin
            cyc();
            if (count == 16'h00FF) begin n = i; break; end
        end
        chk(n == 255, "R2 ticks to TOP 0xFF", n, 255);
        cyc();
        chk(count == 16'h00FE, "R3 step after TOP", int'(count), 16'h00FE);
        // R12: period register below 3 clamps TOP to 3
        wave_sel = 4'd10;
        wr(2'd2, 16'd1);
        mx = 0;
        for (int i = 0; i < 340; i++) begin
            cyc();
            if (i >= 300 && int'(count) > mx) mx = int'(count);
        end
        chk(mx == 3, "R12 clamped TOP", mx, 3);
        // R7: tick low holds everything; unsupported wave_sel ignores ticks
        tick = 1'b0; held = count;
        repeat (6) cyc();
        chk(count == held, "R7 tick low hold", int'(count), int'(held));
        wave_sel = 4'd5; tick = 1'b1;
        repeat (6) cyc();
        chk(count == held, "R7 invalid wave hold", int'(count), int'(held));
        // R10: write-one-to-clear of all flags
        tick = 1'b0; wave_sel = 4'd10;
        wr(2'd3, 16'h000F);
        cyc();
        chk({flag_ovf, flag_cmp_a, flag_cmp_b, flag_period} == 4'b0, "R10 flags cleared",
            {flag_ovf, flag_cmp_a, flag_cmp_b, flag_period}, 0);
        // R11: disconnected channel stays low while compares hit
        mode_a = 2'd0; mode_b = 2'd2; tick = 1'b1;
        wr(2'd2, 16'd12);
        wr(2'd0, 16'd5);
        wr(2'd1, 16'd5);
        for (int i = 0; i < 60; i++) begin
            cyc();
            chk(pwm_a == 1'b0, "R11 pin off", pwm_a, 0);
        end
        // Random phases
        mode_a = 2'd2; mode_b = 2'd3;
        rand_phase(4000, 4'd10, 40, 1'b0);
        rand_phase(4000, 4'd11, 40, 1'b0);
        rand_phase(3000, 4'd1, 300, 1'b0);
        rand_phase(6000, 4'd0, 600, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule